// File: doc/BRIEF.md
# Float Compare and Branch Condition Unit

This block serves a vector shader sequencer in two ways. When a compare instruction issues, it compares the x components and the y components of two single-precision operand vectors. Each lane uses its own operator, taken from the instruction word. The two results are stored in persistent condition flags, called cmp.x and cmp.y below. These flags keep their values until the next compare that is accepted.

The flow-control logic presents a branch instruction word on a separate input. The block returns one condition bit for that word without delay. It forms the bit from the stored flags, a polarity bit for each flag and a 2-bit combine code. For the branch forms that test a uniform, the same word also indexes a small bank of uniform booleans, and the selected value is returned. Software-side logic loads the bank through a simple write port that takes an index and a value.

The float ordering is IEEE-754. Positive and negative zero compare equal, subnormals are ordered by value, and a NaN operand makes every ordered relation false.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is held, and after it is released, both flags read 0.
- R2: A compare is accepted only when `cmp_valid` is 1 and `cmp_instr[31:27]` equals 5'h17. The flags take the new results on the clock edge after acceptance. In any other cycle both flags keep their values.
- R3: cmp.x is the result of `src1_x` op `src2_x`, with the operator given by `cmp_instr[26:24]`. cmp.y is the result of `src1_y` op `src2_y`, with the operator given by `cmp_instr[23:21]`. The operator codes are: 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater, 5 greater-or-equal.
- R4: Operator codes 6 and 7 give 1 for every pair of operands, NaN included.
- R5: +0 and −0 compare equal. If either operand is a NaN, codes 0, 2, 3, 4 and 5 give 0 and code 1 gives 1.
- R6: Negative values, mixed signs, infinities and subnormals are ordered by their real value.
- R7: The polarity bit for cmp.x is `cond_instr[25]` and the polarity bit for cmp.y is `cond_instr[24]`. When a polarity bit is 1, its flag is used as stored. When it is 0, the flag is inverted.
- R8: `cond_instr[23:22]` selects how the two polarity-adjusted terms are combined: 0 gives OR, 1 gives AND, 2 gives the x term alone and 3 gives the y term alone. `cond_out` follows `cond_instr` and the flags combinationally.
- R9: A write with `ub_we` set stores `ub_val` into boolean `ub_idx`. The new value is readable from the next cycle. All booleans reset to 0.
- R10: `ubool_out` returns the boolean selected by `cond_instr[25:22]`. An index of `NUM_BOOLS` (default 8) or higher returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare instruction present |
| cmp_instr | input | 32 | Compare instruction word |
| src1_x | input | 32 | First operand, x component |
| src1_y | input | 32 | First operand, y component |
| src2_x | input | 32 | Second operand, x component |
| src2_y | input | 32 | Second operand, y component |
| cond_instr | input | 32 | Branch instruction word being evaluated |
| ub_we | input | 1 | Uniform boolean write enable |
| ub_idx | input | 3 | Uniform boolean write index |
| ub_val | input | 1 | Uniform boolean write value |
| flag_x | output | 1 | Stored cmp.x |
| flag_y | output | 1 | Stored cmp.y |
| cond_out | output | 1 | Evaluated branch condition |
| ubool_out | output | 1 | Selected uniform boolean |

## Verification
The following behaviours are checked by assertions on every cycle:
- the flags hold when no compare is accepted;
- operator codes 6 and 7 always set their flag;
- a NaN clears every ordered result;
- the single-term and AND combine modes agree with the stored flags and polarity bits;
- an out-of-range boolean index reads 0;
- a boolean write is visible on the next cycle.

Some behaviours can only be shown by the bench's scenarios, which run a behavioural reference model cycle by cycle. These are the numeric ordering across signs, zeros, infinities and subnormals, and the correct operator for each lane. They also include how opcode mismatches interleave with valid compares and the OR mode together with the polarity rules.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  localparam logic [4:0] CMP_OPCODE = 5'h17;

  typedef enum logic [2:0] {
    OP_EQ = 3'd0,
    OP_NE = 3'd1,
    OP_LT = 3'd2,
    OP_LE = 3'd3,
    OP_GT = 3'd4,
    OP_GE = 3'd5,
    OP_T6 = 3'd6,
    OP_T7 = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    CC_OR  = 2'd0,
    CC_AND = 2'd1,
    CC_X   = 2'd2,
    CC_Y   = 2'd3
  } cond_op_e;

  typedef struct packed {
    logic     pol_x;
    logic     pol_y;
    cond_op_e mode;
  } cond_fields_t;

endpackage

// File: rtl/fcc_lane_cmp.sv
module fcc_lane_cmp
  import fcc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int FP_W = 1 + EXP_W + MAN_W
) (
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  input  cmp_op_e         op,
  output logic            res
);

  localparam int MAG_W = FP_W - 1;

  logic             sign_a, sign_b;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             nan_a, nan_b, unordered, both_zero;
  logic             eq_ab, lt_ab, lt_ba;

  assign sign_a    = a[FP_W-1];
  assign sign_b    = b[FP_W-1];
  assign mag_a     = a[MAG_W-1:0];
  assign mag_b     = b[MAG_W-1:0];
  assign nan_a     = (&a[MAG_W-1:MAN_W]) && (|a[MAN_W-1:0]);
  assign nan_b     = (&b[MAG_W-1:MAN_W]) && (|b[MAN_W-1:0]);
  assign unordered = nan_a || nan_b;
  assign both_zero = ~(|mag_a) && ~(|mag_b);

  always_comb begin
    eq_ab = !unordered && ((a == b) || both_zero);
    lt_ab = 1'b0;
    lt_ba = 1'b0;
    if (!unordered && !both_zero) begin
      unique case ({sign_a, sign_b})
        2'b00: begin
          lt_ab = mag_a < mag_b;
          lt_ba = mag_b < mag_a;
        end
        2'b11: begin
          lt_ab = mag_a > mag_b;
          lt_ba = mag_b > mag_a;
        end
        2'b10: lt_ab = 1'b1;
        default: lt_ba = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (op)
      OP_EQ:   res = eq_ab;
      OP_NE:   res = !eq_ab;
      OP_LT:   res = lt_ab;
      OP_LE:   res = lt_ab || eq_ab;
      OP_GT:   res = lt_ba;
      OP_GE:   res = lt_ba || eq_ab;
      default: res = 1'b1;
    endcase
  end

endmodule

// File: rtl/fcc_flag_reg.sv
module fcc_flag_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] q_next;

  always_comb begin
    q_next = q;
    if (en) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/fcc_cond_eval.sv
module fcc_cond_eval
  import fcc_pkg::*;
(
  input  logic         fx,
  input  logic         fy,
  input  cond_fields_t fields,
  output logic         cond
);

  logic term_x, term_y;

  assign term_x = fields.pol_x ? fx : !fx;
  assign term_y = fields.pol_y ? fy : !fy;

  always_comb begin
    unique case (fields.mode)
      CC_OR:   cond = term_x || term_y;
      CC_AND:  cond = term_x && term_y;
      CC_X:    cond = term_x;
      default: cond = term_y;
    endcase
  end

endmodule

// File: rtl/fcc_bool_bank.sv
module fcc_bool_bank #(
  parameter int NUM_BOOLS = 8,
  parameter int SEL_W     = 4,
  localparam int IDX_W    = (NUM_BOOLS > 1) ? $clog2(NUM_BOOLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  input  logic [SEL_W-1:0] ridx,
  output logic             rdata
);

  logic [NUM_BOOLS-1:0] bits_q, bits_next;

  for (genvar g = 0; g < NUM_BOOLS; g++) begin : g_entry
    logic hit;
    assign hit = we && (widx == IDX_W'(g));
    always_comb begin
      bits_next[g] = bits_q[g];
      if (hit) bits_next[g] = wval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_next;
  end

  always_comb begin
    rdata = 1'b0;
    for (int i = 0; i < NUM_BOOLS; i++) begin
      if (32'(ridx) == i) rdata = bits_q[i];
    end
  end

  // R10: out-of-range selects read false
  a_r10_oob_false: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ridx) >= NUM_BOOLS) |-> !rdata);

  // R9: a write is visible on the next cycle
  a_r9_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(widx) < NUM_BOOLS) |=> (bits_q[$past(widx)] == $past(wval)));

endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcc_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int MAN_W     = 23,
  parameter int NUM_BOOLS = 8,
  localparam int FP_W     = 1 + EXP_W + MAN_W,
  localparam int UB_IDX_W = (NUM_BOOLS > 1) ? $clog2(NUM_BOOLS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  input  logic [31:0]         cmp_instr,
  input  logic [FP_W-1:0]     src1_x,
  input  logic [FP_W-1:0]     src1_y,
  input  logic [FP_W-1:0]     src2_x,
  input  logic [FP_W-1:0]     src2_y,
  input  logic [31:0]         cond_instr,
  input  logic                ub_we,
  input  logic [UB_IDX_W-1:0] ub_idx,
  input  logic                ub_val,
  output logic                flag_x,
  output logic                flag_y,
  output logic                cond_out,
  output logic                ubool_out
);

  localparam int LANES = 2;
  localparam int SEL_W = 4;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // compare decode; lane 0 is x, lane 1 is y
  logic                        cmp_fire;
  logic [LANES-1:0][FP_W-1:0]  lane_a, lane_b;
  cmp_op_e [LANES-1:0]         lane_op;
  logic [LANES-1:0]            lane_res, flags_q;

  assign cmp_fire   = cmp_valid && (cmp_instr[31:27] == CMP_OPCODE);
  assign lane_a[0]  = src1_x;
  assign lane_b[0]  = src2_x;
  assign lane_a[1]  = src1_y;
  assign lane_b[1]  = src2_y;
  assign lane_op[0] = cmp_op_e'(cmp_instr[26:24]);
  assign lane_op[1] = cmp_op_e'(cmp_instr[23:21]);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    fcc_lane_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
      .a  (lane_a[l]),
      .b  (lane_b[l]),
      .op (lane_op[l]),
      .res(lane_res[l])
    );
  end

  fcc_flag_reg #(.N(LANES)) u_flags (
    .clk  (clk),
    .rst_n(rst_q),
    .en   (cmp_fire),
    .d    (lane_res),
    .q    (flags_q)
  );

  assign flag_x = flags_q[0];
  assign flag_y = flags_q[1];

  // branch condition
  cond_fields_t cfields;
  assign cfields.pol_x = cond_instr[25];
  assign cfields.pol_y = cond_instr[24];
  assign cfields.mode  = cond_op_e'(cond_instr[23:22]);

  fcc_cond_eval u_cond (
    .fx    (flag_x),
    .fy    (flag_y),
    .fields(cfields),
    .cond  (cond_out)
  );

  // uniform booleans
  fcc_bool_bank #(.NUM_BOOLS(NUM_BOOLS), .SEL_W(SEL_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_q),
    .we   (ub_we),
    .widx (ub_idx),
    .wval (ub_val),
    .ridx (cond_instr[25:22]),
    .rdata(ubool_out)
  );

  // ---------------- assertions ----------------
  logic nan_in_x;
  assign nan_in_x = ((&src1_x[FP_W-2:MAN_W]) && (|src1_x[MAN_W-1:0])) ||
                    ((&src2_x[FP_W-2:MAN_W]) && (|src2_x[MAN_W-1:0]));

  // R2: flags hold without an accepted compare
  a_r2_flags_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !cmp_fire |=> ($stable(flag_x) && $stable(flag_y)));

  // R4: codes 6 and 7 always set the flag
  a_r4_x_true: assert property (@(posedge clk) disable iff (!rst_q)
    (cmp_fire && cmp_instr[26:25] == 2'b11) |=> flag_x);
  a_r4_y_true: assert property (@(posedge clk) disable iff (!rst_q)
    (cmp_fire && cmp_instr[23:22] == 2'b11) |=> flag_y);

  // R5: a NaN makes every ordered relation false
  a_r5_nan_x: assert property (@(posedge clk) disable iff (!rst_q)
    (cmp_fire && nan_in_x && cmp_instr[26:24] != 3'd1 &&
     cmp_instr[26:25] != 2'b11) |=> !flag_x);

  // R7: single-term modes follow the polarity bit
  a_r7_x_term: assert property (@(posedge clk) disable iff (!rst_q)
    (cond_instr[23:22] == 2'd2) |-> (cond_out == (cond_instr[25] ~^ flag_x)));
  a_r7_y_term: assert property (@(posedge clk) disable iff (!rst_q)
    (cond_instr[23:22] == 2'd3) |-> (cond_out == (cond_instr[24] ~^ flag_y)));

  // R8: AND true needs both terms true
  a_r8_and_terms: assert property (@(posedge clk) disable iff (!rst_q)
    (cond_instr[23:22] == 2'd1 && cond_out) |->
      ((cond_instr[25] == flag_x) && (cond_instr[24] == flag_y)));

endmodule

// File: tb/fcmp_cond_unit_test.sv
module fcmp_cond_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid;
  logic [31:0] cmp_instr, src1_x, src1_y, src2_x, src2_y, cond_instr;
  logic        ub_we, ub_val;
  logic [2:0]  ub_idx;
  logic        flag_x, flag_y, cond_out, ubool_out;

  always #2 clk = ~clk;

  fcmp_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_instr(cmp_instr),
    .src1_x(src1_x), .src1_y(src1_y), .src2_x(src2_x), .src2_y(src2_y),
    .cond_instr(cond_instr), .ub_we(ub_we), .ub_idx(ub_idx), .ub_val(ub_val),
    .flag_x(flag_x), .flag_y(flag_y), .cond_out(cond_out), .ubool_out(ubool_out)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference state
  bit    m_fx, m_fy;
  bit    m_bools [8];
  string tag_x = "R1";
  string tag_y = "R1";

  logic [31:0] pool [14] = '{32'h00000000, 32'h80000000, 32'h3f800000,
    32'hbf800000, 32'h40000000, 32'hc0200000, 32'h7f800000, 32'hff800000,
    32'h7fc00000, 32'hffc00001, 32'h00000001, 32'h80000001, 32'h3f000000,
    32'h7f7fffff};

  function automatic real to_real(logic [31:0] f);
    int  e = int'(f[30:23]);
    real m = real'(f[22:0]);
    real v;
    if (e == 255) begin
      if (f[22:0] != 0) return $bitstoreal(64'h7ff8000000000000);
      v = $bitstoreal(64'h7ff0000000000000);
    end else if (e == 0) v = m * (2.0 ** (-149));
    else                 v = (8388608.0 + m) * (2.0 ** (e - 150));
    return f[31] ? -v : v;
  endfunction

  function automatic bit ref_cmp(logic [31:0] a, logic [31:0] b, int op);
    real ra = to_real(a);
    real rb = to_real(b);
    case (op)
      0: return ra == rb;
      1: return ra != rb;
      2: return ra < rb;
      3: return ra <= rb;
      4: return ra > rb;
      5: return ra >= rb;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit is_nan(logic [31:0] f);
    return (f[30:23] == 8'hff) && (f[22:0] != 0);
  endfunction

  function automatic string lane_tag(logic [31:0] a, logic [31:0] b, int op);
    if (op >= 6) return "R4";
    if (is_nan(a) || is_nan(b) || (a[30:0] == 0 && b[30:0] == 0)) return "R5";
    if (a[31] || b[31] || a[30:23] == 8'hff || b[30:23] == 8'hff ||
        a[30:23] == 0 || b[30:23] == 0) return "R6";
    return "R3";
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: drive, check outputs before the edge, advance the model
  task automatic step(bit v, logic [31:0] ci, logic [31:0] ax, logic [31:0] ay,
                      logic [31:0] bx, logic [31:0] by, logic [31:0] cnd,
                      bit we, logic [2:0] wi, bit wv);
    int  mode, idx;
    bit  tx, ty, exp_c, exp_u;
    @(negedge clk);
    cmp_valid = v; cmp_instr = ci; src1_x = ax; src1_y = ay;
    src2_x = bx; src2_y = by; cond_instr = cnd;
    ub_we = we; ub_idx = wi; ub_val = wv;
    #1;
    chk(tag_x, "flag_x", flag_x, m_fx);
    chk(tag_y, "flag_y", flag_y, m_fy);
    tx   = cnd[25] ? m_fx : !m_fx;
    ty   = cnd[24] ? m_fy : !m_fy;
    mode = int'(cnd[23:22]);
    case (mode)
      0: exp_c = tx | ty;
      1: exp_c = tx & ty;
      2: exp_c = tx;
      default: exp_c = ty;
    endcase
    chk((mode >= 2) ? "R7" : "R8", "cond_out", cond_out, exp_c);
    idx   = int'(cnd[25:22]);
    exp_u = (idx < 8) ? m_bools[idx] : 1'b0;
    chk((idx < 8) ? "R9" : "R10", "ubool_out", ubool_out, exp_u);
    if (v && ci[31:27] == 5'h17) begin
      m_fx  = ref_cmp(ax, bx, int'(ci[26:24]));
      m_fy  = ref_cmp(ay, by, int'(ci[23:21]));
      tag_x = lane_tag(ax, bx, int'(ci[26:24]));
      tag_y = lane_tag(ay, by, int'(ci[23:21]));
    end else begin
      tag_x = "R2";
      tag_y = "R2";
    end
    if (we) m_bools[wi] = wv;
  endtask

  function automatic logic [31:0] cmpw(int ox, int oy);
    return {5'h17, 3'(ox), 3'(oy), 21'd0};
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp_valid = 0; cmp_instr = 0; src1_x = 0; src1_y = 0;
    src2_x = 0; src2_y = 0; cond_instr = 0; ub_we = 0; ub_idx = 0; ub_val = 0;
    foreach (m_bools[i]) m_bools[i] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "flag_x in reset", flag_x, 1'b0);
    chk("R1", "flag_y in reset", flag_y, 1'b0);
    chk("R9", "bool in reset", ubool_out, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 32'h00c00000, 0, 0, 0);
    // R5: +0 vs -0 equal; NaN operands
    step(1, cmpw(0, 1), 32'h00000000, 32'h7fc00000, 32'h80000000, 32'h3f800000, 0, 1, 3, 1);
    step(1, cmpw(1, 3), 32'h7fc00000, 32'h80000000, 32'h7fc00000, 32'h00000000, 32'h00c00000, 0, 0, 0);
    // R4: codes 6/7 with NaN
    step(1, cmpw(6, 7), 32'h7fc00000, 32'hffc00001, 32'h3f800000, 32'h7fc00000, 32'h03400000, 0, 0, 0);
    // R2: wrong opcode ignored; valid low ignored
    step(1, {5'h16, 3'd0, 3'd0, 21'd0}, 32'h3f800000, 32'h3f800000, 32'h40000000, 32'h40000000, 32'h02000000, 0, 0, 0);
    step(0, cmpw(0, 0), 32'h3f800000, 32'h3f800000, 32'h40000000, 32'h40000000, 32'h02400000, 0, 0, 0);
    // R6: mixed signs, infinities, subnormals
    step(1, cmpw(2, 4), 32'hbf800000, 32'h00000001, 32'h80000001, 32'h00000000, 32'h01400000, 0, 0, 0);
    step(1, cmpw(3, 5), 32'hff800000, 32'h7f800000, 32'hc0200000, 32'h7f7fffff, 32'h02000000, 1, 7, 1);
    // R10: out-of-range selects
    step(0, 0, 0, 0, 0, 0, 32'h03c00000, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 32'h01c00000, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 32'h02000000, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ci = $urandom;
      if ($urandom_range(0, 9) < 8) ci[31:27] = 5'h17;
      step($urandom_range(0, 3) != 0, ci,
           pool[$urandom_range(0, 13)], pool[$urandom_range(0, 13)],
           pool[$urandom_range(0, 13)], pool[$urandom_range(0, 13)],
           $urandom, $urandom_range(0, 1), 3'($urandom), $urandom_range(0, 1));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule